// File: doc/BRIEF.md
# OTP Automatic Read/Program Sequencer

This block is the mode-control core of a one-time-programmable memory controller. Software writes a start word address, a word count and a three-bit operating mode through a small configuration port. The block decodes the mode into standby, manual read, manual program, automatic read and automatic program, plus three reserved test codes. In the two automatic modes it walks through consecutive macrocell word addresses. It moves 16-bit words between a simple macrocell port and an internal data FIFO that software reaches through push and pop strobes.

The count is stored as length minus one. The start address register advances with each processed word, so once the operation ends it reads back the address that follows the last word handled. A separate output gives the number of words still outstanding, and a ready flag shows whether an automatic operation is in progress. Any change between two non-standby modes is refused, so software must always go back to standby first. An alternate programming source lets exactly one word be written from an external data input, bypassing the FIFO and the count.

Top module: `otp_seq`

## Requirements
- R1: After reset, mode_o is 0 (standby), start_addr_o, count_o and words_left_o are 0, ready_o is 1, fifo_level_o is 0 and no macrocell request is made.
- R2: A configuration write with cfg_sel_i = 0 sets the mode from cfg_wdata_i[2:0], the two-cycle-read option from bit 8 and the alternate-source option from bit 9. It is honoured only if the current mode is 0 or the new mode is 0. Otherwise the write is ignored and mode_o and both options keep their values. cfg_sel_i = 1 writes start_addr_o, and cfg_sel_i = 2 writes count_o.
- R3: In automatic read (mode 3), count_o + 1 words are read from addresses start_addr_o upward and pushed into the FIFO in address order. count_o is left unchanged.
- R4: In both automatic modes, start_addr_o increments once per processed word. When the operation finishes it equals the initial address plus the number of words.
- R5: words_left_o is loaded with count_o + 1 when an automatic operation starts and decrements by one per word, reaching 0 at completion. ready_o is 0 from the cycle after the mode write until the last word, and 1 otherwise.
- R6: With the two-cycle option clear, each automatic read word costs one cycle of mc_req_o. With the option set, it costs two cycles.
- R7: In automatic read, the sequencer stalls while the FIFO is full and resumes when software pops, without losing or repeating a word.
- R8: In automatic program (mode 4, alternate option clear), each FIFO word is written to consecutive addresses with mc_wr_o. The sequencer stalls while the FIFO is empty.
- R9: In automatic program with the alternate option set, exactly one word, taken from alt_data_i, is written at start_addr_o. The FIFO contents and count_o are unchanged.
- R10: In manual modes (1, 2) and reserved modes (5 to 7), no macrocell request is made, ready_o stays 1 and words_left_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Target: 0 mode, 1 start address, 2 count |
| cfg_wdata_i | input | 13 | Configuration write data |
| mode_o | output | 3 | Current mode |
| slow_rd_o | output | 1 | Two-cycle read option |
| alt_src_o | output | 1 | Alternate programming source option |
| start_addr_o | output | 13 | Start/current word address |
| count_o | output | 13 | Word count minus one |
| words_left_o | output | 14 | Words still to process |
| ready_o | output | 1 | 1 when no automatic operation is busy |
| fifo_push_i | input | 1 | Software push (ignored in automatic read or when full) |
| fifo_wdata_i | input | 16 | Software push data |
| fifo_pop_i | input | 1 | Software pop (ignored in automatic program or when empty) |
| fifo_rdata_o | output | 16 | FIFO head word |
| fifo_level_o | output | 3 | Words held in the FIFO |
| mc_req_o | output | 1 | Macrocell access request |
| mc_wr_o | output | 1 | Macrocell write (program) qualifier |
| mc_addr_o | output | 13 | Macrocell word address |
| mc_wdata_o | output | 16 | Macrocell write data |
| mc_rdata_i | input | 16 | Macrocell read data, valid combinationally in the request cycle |
| alt_data_i | input | 16 | Alternate programming word |

## Verification
The assertions assume that the macrocell read data is valid in the same cycle as the request. They also assume that the two-cycle option and the alternate-source option are not rewritten in the middle of an operation, and that software does not abort a running operation by returning to standby. The bench keeps within these assumptions. Its memory model answers reads combinationally and changes options only through standby. It waits for ready_o before each mode change, except in the deliberate check of a refused direct mode change, which targets a finished operation.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [2:0] {
    MD_STBY  = 3'd0,
    MD_MREAD = 3'd1,
    MD_MPROG = 3'd2,
    MD_AREAD = 3'd3,
    MD_APROG = 3'd4,
    MD_TST5  = 3'd5,
    MD_TST6  = 3'd6,
    MD_TST7  = 3'd7
  } otp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;

  localparam int SLOW_BIT = 8;
  localparam int ALT_BIT  = 9;
endpackage

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
  import otp_seq_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          addr_inc_i,
  output otp_mode_e     mode_o,
  output logic          slow_o,
  output logic          alt_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] count_o
);
  otp_mode_e     mode_q;
  logic          slow_q, alt_q;
  logic [AW-1:0] addr_q, count_q;
  otp_mode_e     mode_new;
  logic          mode_ok;

  assign mode_new = otp_mode_e'(wdata_i[2:0]);
  // direct hop between two non-standby modes is refused
  assign mode_ok  = we_i && (sel_i == SEL_MODE) &&
                    ((mode_q == MD_STBY) || (mode_new == MD_STBY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_STBY;
      slow_q <= 1'b0;
      alt_q  <= 1'b0;
    end else if (mode_ok) begin
      mode_q <= mode_new;
      slow_q <= wdata_i[SLOW_BIT];
      alt_q  <= wdata_i[ALT_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (addr_inc_i) begin
      addr_q <= addr_q + 1'b1;
    end else if (we_i && sel_i == SEL_ADDR) begin
      addr_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (we_i && sel_i == SEL_COUNT) begin
      count_q <= wdata_i;
    end
  end

  assign mode_o  = mode_q;
  assign slow_o  = slow_q;
  assign alt_o   = alt_q;
  assign addr_o  = addr_q;
  assign count_o = count_q;

  assert_stby_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> ($past(mode_q) == MD_STBY || mode_q == MD_STBY));
endmodule

// File: rtl/otp_seq_fifo.sv
module otp_seq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  assign head_o  = mem_q[rp_q];
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign level_o = lvl_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o && !pop_i));
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));
endmodule

// File: rtl/otp_seq_engine.sv
module otp_seq_engine
  import otp_seq_pkg::*;
#(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  otp_mode_e     mode_i,
  input  logic          slow_i,
  input  logic          alt_i,
  input  logic [AW-1:0] count_i,
  input  logic          fifo_full_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_head_i,
  input  logic [DW-1:0] alt_data_i,
  output logic          mc_req_o,
  output logic          mc_wr_o,
  output logic [DW-1:0] mc_wdata_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          addr_inc_o,
  output logic [AW:0]   left_o,
  output logic          ready_o
);
  localparam int LW = AW + 1;

  seq_state_e    state_q;
  logic [LW-1:0] left_q;
  logic          ph_q;
  logic          is_rd, is_pg, is_auto, run;
  logic          rd_req, rd_done, wr_go, word_done;

  assign is_rd   = (mode_i == MD_AREAD);
  assign is_pg   = (mode_i == MD_APROG);
  assign is_auto = is_rd || is_pg;
  assign run     = (state_q == ST_RUN);

  // a started slow read finishes its second phase regardless of fill level
  assign rd_req    = run && is_rd && (ph_q || !fifo_full_i);
  assign rd_done   = rd_req && (!slow_i || ph_q);
  assign wr_go     = run && is_pg && (alt_i || !fifo_empty_i);
  assign word_done = rd_done || wr_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      ph_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (is_auto) begin
          state_q <= ST_RUN;
          left_q  <= (is_pg && alt_i) ? LW'(1) : ({1'b0, count_i} + 1'b1);
          ph_q    <= 1'b0;
        end
        ST_RUN: begin
          if (!is_auto) begin
            state_q <= ST_IDLE;
            ph_q    <= 1'b0;
          end else if (word_done) begin
            left_q <= left_q - 1'b1;
            ph_q   <= 1'b0;
            if (left_q == LW'(1)) state_q <= ST_DONE;
          end else if (rd_req) begin
            ph_q <= 1'b1;
          end
        end
        ST_DONE: if (!is_auto) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mc_req_o   = rd_req || wr_go;
  assign mc_wr_o    = wr_go;
  assign mc_wdata_o = alt_i ? alt_data_i : fifo_head_i;
  assign push_o     = rd_done;
  assign pop_o      = wr_go && !alt_i;
  assign addr_inc_o = word_done;
  assign left_o     = left_q;
  assign ready_o    = !(run || (state_q == ST_IDLE && is_auto));

  assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_req_o |-> !ready_o);
  assert_left_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> (left_q == $past(left_q) || left_q == $past(left_q) - 1'b1));
  assert_slow_two_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_req_o && !mc_wr_o && slow_i && !ph_q) |=> mc_req_o);
  assert_alt_one_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_wr_o && alt_i) |=> !mc_wr_o);
  assert_idle_modes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_auto && mode_i != MD_STBY) |-> (!mc_req_o && ready_o));
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter int AW    = 13,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [1:0]                 cfg_sel_i,
  input  logic [AW-1:0]              cfg_wdata_i,
  output logic [2:0]                 mode_o,
  output logic                       slow_rd_o,
  output logic                       alt_src_o,
  output logic [AW-1:0]              start_addr_o,
  output logic [AW-1:0]              count_o,
  output logic [AW:0]                words_left_o,
  output logic                       ready_o,
  input  logic                       fifo_push_i,
  input  logic [DW-1:0]              fifo_wdata_i,
  input  logic                       fifo_pop_i,
  output logic [DW-1:0]              fifo_rdata_o,
  output logic [$clog2(DEPTH+1)-1:0] fifo_level_o,
  output logic                       mc_req_o,
  output logic                       mc_wr_o,
  output logic [AW-1:0]              mc_addr_o,
  output logic [DW-1:0]              mc_wdata_o,
  input  logic [DW-1:0]              mc_rdata_i,
  input  logic [DW-1:0]              alt_data_i
);
  otp_mode_e     mode;
  logic          slow, alt, addr_inc;
  logic [AW-1:0] addr, count;
  logic          f_push, f_pop, f_full, f_empty;
  logic [DW-1:0] f_wdata, f_head;
  logic          e_push, e_pop;

  otp_seq_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .addr_inc_i(addr_inc),
    .mode_o(mode), .slow_o(slow), .alt_o(alt),
    .addr_o(addr), .count_o(count)
  );

  // engine owns the write side in auto read, the read side in auto program
  assign f_push  = (mode == MD_AREAD) ? e_push : (fifo_push_i && !f_full);
  assign f_wdata = (mode == MD_AREAD) ? mc_rdata_i : fifo_wdata_i;
  assign f_pop   = (mode == MD_APROG) ? e_pop : (fifo_pop_i && !f_empty);

  otp_seq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(f_push), .wdata_i(f_wdata), .pop_i(f_pop),
    .head_o(f_head), .full_o(f_full), .empty_o(f_empty),
    .level_o(fifo_level_o)
  );

  otp_seq_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk_i, .rst_ni,
    .mode_i(mode), .slow_i(slow), .alt_i(alt), .count_i(count),
    .fifo_full_i(f_full), .fifo_empty_i(f_empty), .fifo_head_i(f_head),
    .alt_data_i,
    .mc_req_o, .mc_wr_o, .mc_wdata_o,
    .push_o(e_push), .pop_o(e_pop), .addr_inc_o(addr_inc),
    .left_o(words_left_o), .ready_o
  );

  assign mode_o       = mode;
  assign slow_rd_o    = slow;
  assign alt_src_o    = alt;
  assign start_addr_o = addr;
  assign count_o      = count;
  assign mc_addr_o    = addr;
  assign fifo_rdata_o = f_head;

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_req_o && (mc_wr_o || !slow)) |=> (start_addr_o == $past(start_addr_o) + 1'b1));
endmodule

// File: tb/otp_seq_tb.sv
module otp_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [12:0] cfg_wdata = '0;
  logic [2:0]  mode;
  logic        slow_rd, alt_src;
  logic [12:0] start_addr, count;
  logic [13:0] words_left;
  logic        ready;
  logic        fpush = 1'b0, fpop = 1'b0;
  logic [15:0] fwdata = '0, frdata;
  logic [2:0]  flevel;
  logic        mc_req, mc_wr;
  logic [12:0] mc_addr;
  logic [15:0] mc_wdata, mc_rdata;
  logic [15:0] alt_data = '0;

  logic [15:0] mem [64];
  int          rd_cnt = 0, wr_cnt = 0;
  int          tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_seq dut_i (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .mode_o(mode), .slow_rd_o(slow_rd), .alt_src_o(alt_src),
    .start_addr_o(start_addr), .count_o(count),
    .words_left_o(words_left), .ready_o(ready),
    .fifo_push_i(fpush), .fifo_wdata_i(fwdata), .fifo_pop_i(fpop),
    .fifo_rdata_o(frdata), .fifo_level_o(flevel),
    .mc_req_o(mc_req), .mc_wr_o(mc_wr), .mc_addr_o(mc_addr),
    .mc_wdata_o(mc_wdata), .mc_rdata_i(mc_rdata), .alt_data_i(alt_data)
  );

  function automatic logic [15:0] init_word(input int i);
    return 16'hA000 + 16'(i * 7);
  endfunction

  initial for (int i = 0; i < 64; i++) mem[i] = init_word(i);

  assign mc_rdata = mem[mc_addr[5:0]];

  always @(posedge clk) begin
    if (mc_req && mc_wr) begin
      mem[mc_addr[5:0]] <= mc_wdata;
      wr_cnt <= wr_cnt + 1;
    end else if (mc_req) begin
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [12:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] d);
    @(negedge clk);
    fpush = 1'b1; fwdata = d;
    @(negedge clk);
    fpush = 1'b0;
  endtask

  task automatic pop_check(input string tag, input logic [15:0] exp);
    for (int k = 0; k < 100 && flevel == 0; k++) @(negedge clk);
    check(tag, frdata, exp);
    fpop = 1'b1;
    @(negedge clk);
    fpop = 1'b0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 500 && !ready; k++) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 mode", mode, 0);
    check("R1 addr", start_addr, 0);
    check("R1 count", count, 0);
    check("R1 left", words_left, 0);
    check("R1 ready", ready, 1);
    check("R1 level", flevel, 0);
    check("R1 req", mc_req, 0);
  endtask

  task automatic test_read_fast();
    int r0;
    r0 = rd_cnt;
    cfg_write(2'd1, 13'd8);
    cfg_write(2'd2, 13'd5);
    cfg_write(2'd0, 13'd3);
    check("R5 ready busy", ready, 0);
    repeat (30) @(negedge clk);
    check("R7 stall level", flevel, 4);
    check("R7 stall left", words_left, 2);
    check("R7 stall ready", ready, 0);
    for (int i = 0; i < 6; i++) pop_check("R3 R7 read data", init_word(8 + i));
    wait_ready();
    check("R5 left done", words_left, 0);
    check("R5 ready done", ready, 1);
    check("R4 addr end", start_addr, 14);
    check("R3 count kept", count, 5);
    check("R6 fast req cycles", rd_cnt - r0, 6);
    cfg_write(2'd0, 13'd4);
    check("R2 direct change refused", mode, 3);
    cfg_write(2'd0, 13'd0);
    check("R2 back to standby", mode, 0);
  endtask

  task automatic test_read_slow();
    int r0;
    r0 = rd_cnt;
    cfg_write(2'd1, 13'd30);
    cfg_write(2'd2, 13'd2);
    cfg_write(2'd0, 13'h103);
    check("R2 slow option", slow_rd, 1);
    wait_ready();
    check("R6 slow req cycles", rd_cnt - r0, 6);
    check("R3 slow level", flevel, 3);
    for (int i = 0; i < 3; i++) pop_check("R3 slow data", init_word(30 + i));
    cfg_write(2'd0, 13'd0);
  endtask

  task automatic test_prog();
    int w0;
    w0 = wr_cnt;
    cfg_write(2'd1, 13'd20);
    cfg_write(2'd2, 13'd2);
    cfg_write(2'd0, 13'd4);
    repeat (10) @(negedge clk);
    check("R8 empty stall ready", ready, 0);
    check("R8 empty stall left", words_left, 3);
    check("R8 empty stall writes", wr_cnt - w0, 0);
    push_word(16'h1111);
    repeat (5) @(negedge clk);
    check("R8 first word", mem[20], 16'h1111);
    check("R5 left after one", words_left, 2);
    push_word(16'h2222);
    push_word(16'h3333);
    wait_ready();
    check("R8 second word", mem[21], 16'h2222);
    check("R8 third word", mem[22], 16'h3333);
    check("R4 prog addr end", start_addr, 23);
    check("R8 fifo drained", flevel, 0);
    cfg_write(2'd0, 13'd0);
  endtask

  task automatic test_alt();
    int w0;
    push_word(16'h7777);
    push_word(16'h8888);
    w0 = wr_cnt;
    alt_data = 16'h5A5A;
    cfg_write(2'd1, 13'd40);
    cfg_write(2'd2, 13'd7);
    cfg_write(2'd0, 13'h204);
    wait_ready();
    check("R9 alt word", mem[40], 16'h5A5A);
    check("R9 next untouched", mem[41], init_word(41));
    check("R9 one write", wr_cnt - w0, 1);
    check("R9 count kept", count, 7);
    check("R9 fifo kept", flevel, 2);
    check("R9 addr", start_addr, 41);
    check("R9 left", words_left, 0);
    cfg_write(2'd0, 13'd0);
    pop_check("R9 fifo head", 16'h7777);
    pop_check("R9 fifo next", 16'h8888);
  endtask

  task automatic test_idle_modes();
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cfg_write(2'd0, 13'd5);
    check("R2 reserved accepted", mode, 5);
    repeat (10) @(negedge clk);
    check("R10 reserved ready", ready, 1);
    check("R10 reserved left", words_left, 0);
    cfg_write(2'd0, 13'd1);
    check("R2 reserved to manual refused", mode, 5);
    cfg_write(2'd0, 13'd0);
    cfg_write(2'd0, 13'd1);
    check("R2 manual accepted", mode, 1);
    repeat (10) @(negedge clk);
    check("R10 manual ready", ready, 1);
    check("R10 no requests", (rd_cnt - r0) + (wr_cnt - w0), 0);
    cfg_write(2'd0, 13'd0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_read_fast();
    test_read_slow();
    test_prog();
    test_alt();
    test_idle_modes();
    finish_run();
  end
endmodule